// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block sits between a simple synchronous host and an external asynchronous static RAM that holds 131,072 bytes. The host presents one byte access at a time over a valid/ready handshake. The controller then drives the RAM's address, its two chip enables of opposite polarity, the active-low output enable and the active-low write enable. It also drives the shared 8-bit data bus, with a separate enable for the pad's tri-state driver. Returned read data comes back to the host with a one-cycle valid pulse.

Every phase length is a parameter counted in clock cycles. The integrator rounds the RAM's nanosecond limits up to whole cycles of the system clock. Any parameter below one is treated as one. The write strobe lasts for the larger of the strobe-width and data-setup lengths, so the setup limit measured to the closing edge of the strobe always holds. The data bus is sequenced so the controller never drives it while the RAM might be driving it. A read followed by a write gets an idle turnaround gap with the RAM deselected and its outputs disabled.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, the controller holds `mem_ce_n`=1, `mem_ce`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: A write request holds `mem_we_n`=0 for exactly max(`WR_CYC`,`DS_CYC`) cycles. During those cycles `mem_ce_n`=0, `mem_ce`=1, `mem_oe_n`=1, `mem_dq_oe`=1, `mem_dq_out` equals the request's write data and `mem_addr` equals the request's address.
- R3: After the write strobe ends there is exactly one hold cycle. In it `mem_we_n`=1, both chip enables stay active, and the address and the driven data stay unchanged. After that cycle the chip is deselected and the driver is off.
- R4: `mem_dq_oe` is 1 only in cycles where `mem_oe_n` is 1. `mem_we_n` is 0 only while both chip enables are active and `mem_oe_n` is 1.
- R5: `mem_addr` does not change in any cycle where the chip stays selected from the previous cycle.
- R6: A read request holds `mem_oe_n`=0, `mem_ce_n`=0 and `mem_ce`=1 for exactly `RD_CYC` cycles. During those cycles `mem_we_n`=1 and `mem_dq_oe`=0.
- R7: The RAM bus value present in the last read cycle appears on `rsp_rdata` in the next cycle. In that cycle `rsp_valid` is 1 for exactly one cycle.
- R8: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the access completes. That is `RD_CYC` cycles for a read, and max(`WR_CYC`,`DS_CYC`)+1 cycles for a write plus any turnaround.
- R9: A write whose previous access was a read first spends exactly `TA_CYC` cycles with the chip deselected, `mem_oe_n`=1 and the driver off. A write after a write, or any read, gets no such gap.
- R10: The full 17-bit address range reaches `mem_addr` unchanged, including 0x00000 and 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host presents an access |
| req_ready | output | 1 | Controller idle and able to take an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Captured read data |
| mem_addr | output | 17 | RAM address pins |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data toward the RAM |
| mem_dq_oe | output | 1 | Enable of the data bus driver |
| mem_dq_in | input | 8 | Data from the RAM |

## Verification
Bus exclusivity, write-enable qualification, address stability while selected, data hold around the strobe's closing edge, the single-cycle response pulse and ready dropping after acceptance are all checked on every cycle. The exact lengths of the read, strobe, hold and turnaround phases can only be shown by the directed scenarios. The same holds for read data passing through a model of the RAM, and for the turnaround appearing only on a read-to-write switch. Those scenarios count phase cycles and compare stored and returned bytes at the corner addresses.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared types for the asynchronous SRAM port controller.
// Holds the sequencer state encoding and the decode from state to the
// logical (active-high) strobe set. Assumes one access in flight at a time.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_TURN  = 3'd2,
        ST_WRITE = 3'd3,
        ST_WHOLD = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic sel;    // both chip enables active
        logic rd_en;  // RAM output enable active
        logic wr_en;  // RAM write enable active
        logic drive;  // controller drives the data bus
    } strobe_t;

    // Map a sequencer state to the strobes it asserts.
    function automatic strobe_t phase_strobes(input seq_state_e st);
        strobe_t s;
        s = '0;
        case (st)
            ST_READ:  begin s.sel = 1'b1; s.rd_en = 1'b1; end
            ST_WRITE: begin s.sel = 1'b1; s.wr_en = 1'b1; s.drive = 1'b1; end
            ST_WHOLD: begin s.sel = 1'b1; s.drive = 1'b1; end
            default:  s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Phase timer: counts cycles spent in the current phase and flags the
// last one. Assumes the sequencer restarts it on every phase change and
// holds last_idx constant while a phase runs.
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] last_idx,
    output logic             at_end
);

    logic [CNT_W-1:0] cnt_q;

    // Cycle counter within the running phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    // Last cycle of the phase.
    always_comb at_end = (cnt_q == last_idx);

endmodule

// File: rtl/sram_seq_fsm.sv
// Access sequencer: takes one host request, walks the read, turnaround,
// write-strobe and write-hold phases, and remembers whether the RAM drove
// the bus last so a following write gets a turnaround gap.
// Assumes phase lengths are already clamped to at least one cycle.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W   = 2,
    parameter int RD_LEN  = 2,
    parameter int STB_LEN = 2,
    parameter int TA_LEN  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             at_end,
    output seq_state_e       state,
    output logic             restart,
    output logic [CNT_W-1:0] last_idx,
    output logic             accept,
    output logic             capture
);

    seq_state_e state_q, state_d;
    logic       bus_hot_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (req_valid) begin
                          if (req_write) state_d = bus_hot_q ? ST_TURN : ST_WRITE;
                          else           state_d = ST_READ;
                      end
            ST_READ:  if (at_end) state_d = ST_IDLE;
            ST_TURN:  if (at_end) state_d = ST_WRITE;
            ST_WRITE: if (at_end) state_d = ST_WHOLD;
            ST_WHOLD: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Tracks whether the last access let the RAM drive the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)                          bus_hot_q <= 1'b0;
        else if (state_q == ST_READ && at_end) bus_hot_q <= 1'b1;
        else if (state_d == ST_WRITE)        bus_hot_q <= 1'b0;
    end

    // Phase length selection for the timer.
    always_comb begin
        case (state_q)
            ST_READ:  last_idx = CNT_W'(RD_LEN - 1);
            ST_TURN:  last_idx = CNT_W'(TA_LEN - 1);
            ST_WRITE: last_idx = CNT_W'(STB_LEN - 1);
            default:  last_idx = '0;
        endcase
    end

    // Handshake and control outputs.
    always_comb begin
        state   = state_q;
        restart = (state_d != state_q) || (state_q == ST_IDLE);
        accept  = (state_q == ST_IDLE) && req_valid;
        capture = (state_q == ST_READ) && at_end;
    end

endmodule

// File: rtl/sram_bus_side.sv
// Bus-side datapath: latches the accepted request, decodes the RAM strobes
// from the sequencer state, and captures read data with a one-cycle pulse.
// Assumes address and write data are only loaded while idle.
module sram_bus_side
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rsp_q;
    strobe_t           stb;

    // Request latch, loaded on acceptance and held for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Read capture at the end of the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            rsp_q <= capture;
            if (capture) rdata_q <= mem_dq_in;
        end
    end

    // Strobe decode and pin polarity.
    always_comb begin
        stb        = phase_strobes(state);
        mem_addr   = addr_q;
        mem_ce_n   = ~stb.sel;
        mem_ce     = stb.sel;
        mem_oe_n   = ~stb.rd_en;
        mem_we_n   = ~stb.wr_en;
        mem_dq_oe  = stb.drive;
        mem_dq_out = wdata_q;
        rsp_valid  = rsp_q;
        rsp_rdata  = rdata_q;
    end

endmodule

// File: rtl/sram_port_ctrl.sv
// Top: synchronous host port to an asynchronous byte-wide SRAM.
// Clamps the phase parameters to at least one cycle, derives the strobe
// length from width and data-setup limits, and wires sequencer, timer and
// bus-side datapath. Assumes one outstanding access; the bus data pins use
// a separate driver enable.
module sram_port_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int RD_CYC = 2,
    parameter int WR_CYC = 2,
    parameter int DS_CYC = 2,
    parameter int TA_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int RD_LEN  = (RD_CYC < 1) ? 1 : RD_CYC;
    localparam int WR_LEN  = (WR_CYC < 1) ? 1 : WR_CYC;
    localparam int DS_LEN  = (DS_CYC < 1) ? 1 : DS_CYC;
    localparam int TA_LEN  = (TA_CYC < 1) ? 1 : TA_CYC;
    localparam int STB_LEN = (WR_LEN > DS_LEN) ? WR_LEN : DS_LEN;
    localparam int MAX_A   = (RD_LEN > STB_LEN) ? RD_LEN : STB_LEN;
    localparam int MAX_LEN = (MAX_A > TA_LEN) ? MAX_A : TA_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    seq_state_e       state;
    logic             restart;
    logic             at_end;
    logic [CNT_W-1:0] last_idx;
    logic             accept;
    logic             capture;

    sram_seq_fsm #(
        .CNT_W  (CNT_W),
        .RD_LEN (RD_LEN),
        .STB_LEN(STB_LEN),
        .TA_LEN (TA_LEN)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .at_end   (at_end),
        .state    (state),
        .restart  (restart),
        .last_idx (last_idx),
        .accept   (accept),
        .capture  (capture)
    );

    sram_phase_timer #(
        .CNT_W(CNT_W)
    ) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .last_idx(last_idx),
        .at_end  (at_end)
    );

    sram_bus_side #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) bus_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_in (mem_dq_in),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_ce    (mem_ce),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dq_out(mem_dq_out),
        .mem_dq_oe (mem_dq_oe),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // Host may issue a request only while the sequencer is idle.
    always_comb req_ready = (state == ST_IDLE);

endmodule

// File: rtl/sram_port_ctrl_chk.sv
// Checker: cycle-by-cycle protocol properties of the SRAM port controller,
// attached to every instance of the top by bind. Observes ports only.
module sram_port_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    AST_DRV_ONLY_WHEN_RAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n) mem_dq_oe |-> mem_oe_n); // R4
    AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> (!mem_ce_n && mem_ce && mem_oe_n && mem_dq_oe)); // R4
    AST_CE_PAIR_AGREE: assert property (@(posedge clk) disable iff (!rst_n) mem_ce_n != mem_ce); // R1
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R5
    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_dq_out) && $stable(mem_addr))); // R3
    AST_DRIVER_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_dq_oe) |-> $past(mem_oe_n)); // R9
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R7
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !req_ready); // R8

endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce    (mem_ce),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_port_ctrl_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the SRAM port controller with a behavioural RAM model.
module sram_port_ctrl_tb_top;

    localparam int RD  = 3;
    localparam int WR  = 2;
    localparam int DS  = 3;
    localparam int TA  = 2;
    localparam int STB = (WR > DS) ? WR : DS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int n_cmp = 0;
    int n_bad = 0;
    bit last_rd = 1'b0;
    logic [7:0] ram   [int];
    logic [7:0] shadow[int];

    always #2.5 clk = ~clk;

    sram_port_ctrl #(
        .RD_CYC(RD), .WR_CYC(WR), .DS_CYC(DS), .TA_CYC(TA)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // RAM model: stores on the closing edge of the write strobe.
    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n && mem_ce) ram[int'(mem_addr)] = mem_dq_out;
    end

    // RAM model: drives read data while selected with outputs enabled.
    always @(negedge clk) begin
        if (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n && ram.exists(int'(mem_addr)))
            mem_dq_in <= ram[int'(mem_addr)];
        else
            mem_dq_in <= 8'hEE;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One write access; counts each phase while ready is low.
    task automatic do_write(input logic [16:0] a, input logic [7:0] d);
        int turn = 0, stb = 0, hold = 0, busy = 0, bad = 0;
        int exp_turn = last_rd ? TA : 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready before write", int'(req_ready), 1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && busy < 64) begin
            busy++;
            if (mem_ce_n) begin
                turn++;
                if (!mem_oe_n || mem_dq_oe || mem_ce) bad++;
            end else if (!mem_we_n) begin
                stb++;
                if (!mem_ce || !mem_oe_n || !mem_dq_oe || mem_dq_out != d || mem_addr != a) bad++;
            end else begin
                hold++;
                if (!mem_dq_oe || mem_dq_out != d || mem_addr != a || !mem_oe_n || !mem_ce) bad++;
            end
            @(negedge clk);
        end
        chk(bad == 0, "R2 R3 R4 R10 write strobe/pin values", bad, 0);
        chk(stb == STB, "R2 strobe length", stb, STB);
        chk(hold == 1, "R3 hold cycle count", hold, 1);
        chk(turn == exp_turn, "R9 turnaround cycles", turn, exp_turn);
        chk(busy == exp_turn + STB + 1, "R8 busy cycles on write", busy, exp_turn + STB + 1);
        chk(mem_ce_n && !mem_ce && mem_we_n && !mem_dq_oe, "R3 released after write",
            int'({mem_ce_n, mem_ce, mem_we_n, mem_dq_oe}), 4'b1010);
        shadow[int'(a)] = d;
        last_rd = 1'b0;
    endtask

    // One read access; checks phase length and returned byte.
    task automatic do_read(input logic [16:0] a);
        int rd = 0, busy = 0, bad = 0;
        logic [7:0] exp_d = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'hEE;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready before read", int'(req_ready), 1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && busy < 64) begin
            busy++;
            if (!mem_oe_n) rd++;
            if (mem_ce_n || !mem_ce || !mem_we_n || mem_dq_oe || mem_addr != a || rsp_valid) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R6 R10 read pin values", bad, 0);
        chk(rd == RD, "R6 read phase length", rd, RD);
        chk(busy == RD, "R8 busy cycles on read", busy, RD);
        chk(rsp_valid == 1'b1, "R7 valid with ready", int'(rsp_valid), 1);
        chk(rsp_rdata == exp_d, "R7 read data", int'(rsp_rdata), int'(exp_d));
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R7 valid single pulse", int'(rsp_valid), 0);
        last_rd = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
            "R1 pins in reset", int'({mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe}), 5'b10110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe,
            "R1 idle after reset", int'(req_ready), 1);
    endtask

    task automatic t_basic();
        do_write(17'h00123, 8'hA5);
        do_read(17'h00123);
    endtask

    task automatic t_corners();
        do_write(17'h1FFFF, 8'h3C);
        do_write(17'h00000, 8'hC3);
        do_read(17'h1FFFF);
        do_read(17'h00000);
    endtask

    task automatic t_read_then_write();
        do_read(17'h00123);
        do_write(17'h0ABCD, 8'h5A);
        do_read(17'h0ABCD);
    endtask

    task automatic t_writes_back_to_back();
        for (int i = 0; i < 4; i++) do_write(17'(17'h10000 + i), 8'(8'h11 * (i + 1)));
        for (int i = 0; i < 4; i++) do_read(17'(17'h10000 + i));
    endtask

    initial begin
        t_reset();
        t_basic();
        t_corners();
        t_read_then_write();
        t_writes_back_to_back();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule